// File: doc/BRIEF.md
# Destination Ring Completion Writer

This block closes out receive transfers on the destination side of a copy engine. Host software keeps a ring of empty receive descriptors, each posted with a buffer address and a zero byte count. Software publishes how far it has filled the ring by writing a destination write-index register. When a transfer arrives from the payload path as one fragment, or as a gather list of several fragments, the block claims the oldest posted descriptor. It writes the total byte count and a flags word into that descriptor. Only after memory acknowledges the write does it advance its readable read-index and emit a one-cycle copy-complete pulse.

A nonzero byte count in a descriptor is the completion marker. A descriptor that software reaches with a zero count is treated as not done, even if the read index has already moved past it. The block therefore never writes a zero count, and it orders the write-back strictly before the index update. When every posted buffer is in use (the read index equals the masked write index), the block holds off the first fragment of the next transfer and raises a stall flag.

Control is one four-state machine:
- IDLE waits for a first fragment. It goes to GATHER when the fragment has more to follow. It goes to WRITE when the fragment is the last one and carries data. It stays in IDLE when a lone fragment carries zero bytes.
- GATHER accepts further fragments. It goes to WRITE on a last fragment with a nonzero running total, and back to IDLE when the total is zero.
- WRITE presents the descriptor write-back and moves to DONE on the memory acknowledge.
- DONE pulses copy-complete and returns to IDLE.

Top module: `dring_cmpl_writer`

## Requirements
- R1: While reset is held, and in the first cycle after it, `rd_idx` is 0 and `wb_valid` and `copy_done` are 0.
- R2: Only the low log2(ring size) bits of `host_wr_idx` take part. When these equal the read slot, a first fragment is not accepted: `xfer_ready` is 0, and `ring_stall` is 1 while `xfer_valid` is high. Acceptance resumes as soon as the masked write index moves on.
- R3: A single-fragment transfer (`xfer_more`=0) produces one write-back. In that write-back, `wb_slot` equals the read slot and `wb_len` equals the fragment length. `wb_flags` bit 0 holds the swap indication, and bits META_W:1 hold the metadata.
- R4: Fragments with `xfer_more`=1, followed by one with `xfer_more`=0, form one transfer. That transfer gives one write-back whose length is the sum of the fragment lengths (modulo 2^LEN_W). Its metadata and swap bit are taken from the first fragment.
- R5: While `wb_valid` is 1 and `wb_ack` is 0, `wb_valid`, `wb_slot`, `wb_len` and `wb_flags` hold their values.
- R6: `rd_idx` changes only on the clock edge at which `wb_valid` and `wb_ack` are both 1. It never moves before the write-back is acknowledged.
- R7: Each acknowledged write-back gives exactly one single-cycle `copy_done` pulse. The pulse is in the cycle in which `rd_idx` first shows the advanced value.
- R8: The read slot advances by one per completion and wraps from ring size minus 1 to 0.
- R9: A transfer whose total length is zero is consumed without a write-back, without an index change and without a pulse, so `wb_len` is never 0 while `wb_valid` is 1.
- R10: With the masked write index one slot behind the read slot, exactly ring size minus 1 transfers complete before R2 stalls the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr_idx | input | IDX_REG_W | Destination write-index register written by software |
| rd_idx | output | IDX_REG_W | Readable destination read-index (zero-extended slot) |
| xfer_valid | input | 1 | Incoming fragment valid |
| xfer_ready | output | 1 | Fragment accepted when high with `xfer_valid` |
| xfer_more | input | 1 | 1 = further fragments of this gather list follow |
| xfer_len | input | LEN_W | Fragment byte count |
| xfer_meta | input | META_W | Transfer metadata |
| xfer_swap | input | 1 | Byte-swap indication from the source side |
| ring_stall | output | 1 | Fragment waiting but no posted buffer is free |
| wb_valid | output | 1 | Descriptor write-back request |
| wb_slot | output | RING_LG2 | Ring slot being written back |
| wb_len | output | LEN_W | Byte count written into the descriptor |
| wb_flags | output | META_W+1 | {metadata, swap} written into the descriptor flags |
| wb_ack | input | 1 | Memory accepted the write-back |
| copy_done | output | 1 | One-cycle copy-complete event |

## Verification
The hardest situation to reach is a full ring. The masked write index must sit one slot behind the read slot, and the read slot must wrap through zero, before the stall can be seen on the last free buffer. The bench gets there by first draining a table of single and gathered transfers with varied acknowledge delays. It then parks the write index with extra upper bits set and runs ring size minus 1 transfers across the wrap point, so the stall appears exactly where the ring runs out.

// File: rtl/dcw_pkg.sv
package dcw_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_GATHER = 2'd1,
        ST_WRITE  = 2'd2,
        ST_DONE   = 2'd3
    } dcw_state_e;

endpackage

// File: rtl/dcw_avail.sv
// Posted-buffer check: compares the masked software write index with the read slot.
module dcw_avail #(
    parameter int RING_LG2  = 3,
    parameter int IDX_REG_W = 16
) (
    input  logic [IDX_REG_W-1:0] host_wr_idx,
    input  logic [RING_LG2-1:0]  rd_slot,
    output logic [RING_LG2-1:0]  wr_slot,
    output logic                 slot_free
);
    logic unused_hi_bits;

    assign wr_slot        = host_wr_idx[RING_LG2-1:0];
    assign unused_hi_bits = ^host_wr_idx[IDX_REG_W-1:RING_LG2];
    assign slot_free      = (wr_slot != rd_slot);
endmodule

// File: rtl/dcw_accum.sv
// Gather accumulator: sums fragment lengths, latches metadata from the first fragment.
module dcw_accum #(
    parameter int LEN_W  = 16,
    parameter int META_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              add,
    input  logic [LEN_W-1:0]  frag_len,
    input  logic [META_W-1:0] frag_meta,
    input  logic              frag_swap,
    output logic [LEN_W-1:0]  total_len,
    output logic [META_W-1:0] meta_q,
    output logic              swap_q,
    output logic              zero_if_first,
    output logic              zero_if_more
);
    logic [LEN_W-1:0] sum_more;
    logic [LEN_W-1:0] next_total;

    assign sum_more      = total_len + frag_len;
    assign zero_if_first = (frag_len == '0);
    assign zero_if_more  = (sum_more == '0);

    always_comb begin
        next_total = total_len;
        if (load)
            next_total = frag_len;
        else if (add)
            next_total = sum_more;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            total_len <= '0;
            meta_q    <= '0;
            swap_q    <= 1'b0;
        end else begin
            total_len <= next_total;
            if (load) begin
                meta_q <= frag_meta;
                swap_q <= frag_swap;
            end
        end
    end
endmodule

// File: rtl/dcw_slot_ctr.sv
// Read-slot counter; wraps through the power-of-two ring by its own width.
module dcw_slot_ctr #(
    parameter int RING_LG2 = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                step,
    output logic [RING_LG2-1:0] slot
);
    localparam logic [RING_LG2-1:0] ONE = RING_LG2'(1);

    always_ff @(posedge clk) begin
        if (!rst_n)
            slot <= '0;
        else if (step)
            slot <= slot + ONE;
    end
endmodule

// File: rtl/dcw_ctrl.sv
// Completion sequencer: IDLE -> GATHER -> WRITE -> DONE.
module dcw_ctrl
    import dcw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic xfer_valid,
    input  logic xfer_more,
    input  logic slot_free,
    input  logic zero_if_first,
    input  logic zero_if_more,
    input  logic wb_ack,
    output logic xfer_ready,
    output logic ring_stall,
    output logic acc_load,
    output logic acc_add,
    output logic wb_valid,
    output logic step,
    output logic copy_done
);
    dcw_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d    = state_q;
        xfer_ready = 1'b0;
        ring_stall = 1'b0;
        acc_load   = 1'b0;
        acc_add    = 1'b0;
        wb_valid   = 1'b0;
        step       = 1'b0;
        copy_done  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                xfer_ready = slot_free;
                ring_stall = xfer_valid && !slot_free;
                if (xfer_valid && slot_free) begin
                    acc_load = 1'b1;
                    if (xfer_more)
                        state_d = ST_GATHER;
                    else if (!zero_if_first)
                        state_d = ST_WRITE;
                end
            end
            ST_GATHER: begin
                xfer_ready = 1'b1;
                if (xfer_valid) begin
                    acc_add = 1'b1;
                    if (!xfer_more)
                        state_d = zero_if_more ? ST_IDLE : ST_WRITE;
                end
            end
            ST_WRITE: begin
                wb_valid = 1'b1;
                if (wb_ack) begin
                    step    = 1'b1;
                    state_d = ST_DONE;
                end
            end
            ST_DONE: begin
                copy_done = 1'b1;
                state_d   = ST_IDLE;
            end
        endcase
    end

    // R7: completion event never lasts more than one cycle
    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        copy_done |=> !copy_done);

    // R7: an acknowledged write-back is followed by the event
    a_r7_done_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && wb_ack) |=> copy_done);

    // R2: no stall indication while a fragment is being taken
    a_r2_stall_excl: assert property (@(posedge clk) disable iff (!rst_n)
        ring_stall |-> !xfer_ready);
endmodule

// File: rtl/dring_cmpl_writer.sv
module dring_cmpl_writer #(
    parameter int RING_LG2  = 3,
    parameter int IDX_REG_W = 16,
    parameter int LEN_W     = 16,
    parameter int META_W    = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [IDX_REG_W-1:0] host_wr_idx,
    output logic [IDX_REG_W-1:0] rd_idx,
    input  logic                 xfer_valid,
    output logic                 xfer_ready,
    input  logic                 xfer_more,
    input  logic [LEN_W-1:0]     xfer_len,
    input  logic [META_W-1:0]    xfer_meta,
    input  logic                 xfer_swap,
    output logic                 ring_stall,
    output logic                 wb_valid,
    output logic [RING_LG2-1:0]  wb_slot,
    output logic [LEN_W-1:0]     wb_len,
    output logic [META_W:0]      wb_flags,
    input  logic                 wb_ack,
    output logic                 copy_done
);
    localparam int PAD_W = IDX_REG_W - RING_LG2;
    localparam logic [RING_LG2-1:0] ONE = RING_LG2'(1);

    logic [RING_LG2-1:0] rd_slot;
    logic [RING_LG2-1:0] wr_slot;
    logic                slot_free;
    logic                acc_load, acc_add, step;
    logic                zero_if_first, zero_if_more;
    logic [LEN_W-1:0]    total_len;
    logic [META_W-1:0]   meta_q;
    logic                swap_q;

    dcw_avail #(.RING_LG2(RING_LG2), .IDX_REG_W(IDX_REG_W)) u_avail (
        .host_wr_idx (host_wr_idx),
        .rd_slot     (rd_slot),
        .wr_slot     (wr_slot),
        .slot_free   (slot_free)
    );

    dcw_accum #(.LEN_W(LEN_W), .META_W(META_W)) u_accum (
        .clk           (clk),
        .rst_n         (rst_n),
        .load          (acc_load),
        .add           (acc_add),
        .frag_len      (xfer_len),
        .frag_meta     (xfer_meta),
        .frag_swap     (xfer_swap),
        .total_len     (total_len),
        .meta_q        (meta_q),
        .swap_q        (swap_q),
        .zero_if_first (zero_if_first),
        .zero_if_more  (zero_if_more)
    );

    dcw_slot_ctr #(.RING_LG2(RING_LG2)) u_slot (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (step),
        .slot  (rd_slot)
    );

    dcw_ctrl u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .xfer_valid    (xfer_valid),
        .xfer_more     (xfer_more),
        .slot_free     (slot_free),
        .zero_if_first (zero_if_first),
        .zero_if_more  (zero_if_more),
        .wb_ack        (wb_ack),
        .xfer_ready    (xfer_ready),
        .ring_stall    (ring_stall),
        .acc_load      (acc_load),
        .acc_add       (acc_add),
        .wb_valid      (wb_valid),
        .step          (step),
        .copy_done     (copy_done)
    );

    assign rd_idx   = {{PAD_W{1'b0}}, rd_slot};
    assign wb_slot  = rd_slot;
    assign wb_len   = total_len;
    assign wb_flags = {meta_q, swap_q};

    // R6: read index holds unless the write-back was acknowledged
    a_r6_idx_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        !(wb_valid && wb_ack) |=> $stable(rd_idx));

    // R8: each acknowledged write-back moves the slot by exactly one, modulo ring size
    a_r8_idx_step: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && wb_ack) |=> (rd_idx[RING_LG2-1:0] == $past(rd_idx[RING_LG2-1:0]) + ONE));

    // R5: write-back request is held steady until acknowledged
    a_r5_wb_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && !wb_ack) |=> (wb_valid && $stable(wb_len) && $stable(wb_flags) && $stable(wb_slot)));

    // R9: completion marker is never zero
    a_r9_len_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> (wb_len != '0));

    // R2: a new transfer is only taken when a posted slot exists
    a_r2_take_posted: assert property (@(posedge clk) disable iff (!rst_n)
        acc_load |-> (host_wr_idx[RING_LG2-1:0] != rd_idx[RING_LG2-1:0]));
endmodule

// File: tb/dring_cmpl_writer_tb_top.sv
module dring_cmpl_writer_tb_top;
    localparam int RING_LG2  = 3;
    localparam int IDX_REG_W = 16;
    localparam int LEN_W     = 16;
    localparam int META_W    = 8;
    localparam int NVEC      = 8;

    // row: {more, len[16], meta[8], swap, ack_delay[4]}
    localparam logic [29:0] VEC [NVEC] = '{
        {1'b0, 16'd5,      8'h11, 1'b0, 4'd0},
        {1'b1, 16'd3,      8'h22, 1'b1, 4'd0},
        {1'b1, 16'd4,      8'h33, 1'b0, 4'd0},
        {1'b0, 16'd6,      8'h44, 1'b0, 4'd1},
        {1'b0, 16'hFFFF,   8'h55, 1'b1, 4'd3},
        {1'b0, 16'd1,      8'h66, 1'b0, 4'd0},
        {1'b1, 16'd0,      8'h77, 1'b0, 4'd0},
        {1'b0, 16'd9,      8'h88, 1'b1, 4'd2}
    };

    logic clk = 1'b0;
    logic rst_n;
    logic [IDX_REG_W-1:0] host_wr_idx;
    logic [IDX_REG_W-1:0] rd_idx;
    logic xfer_valid, xfer_ready, xfer_more, xfer_swap, ring_stall;
    logic [LEN_W-1:0] xfer_len;
    logic [META_W-1:0] xfer_meta;
    logic wb_valid, wb_ack, copy_done;
    logic [RING_LG2-1:0] wb_slot;
    logic [LEN_W-1:0] wb_len;
    logic [META_W:0] wb_flags;

    int n_chk = 0;
    int n_bad = 0;
    int cc_cnt = 0;
    int exp_slot = 0;

    always #4 clk = ~clk;

    dring_cmpl_writer #(.RING_LG2(RING_LG2), .IDX_REG_W(IDX_REG_W),
                        .LEN_W(LEN_W), .META_W(META_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .host_wr_idx(host_wr_idx), .rd_idx(rd_idx),
        .xfer_valid(xfer_valid), .xfer_ready(xfer_ready), .xfer_more(xfer_more),
        .xfer_len(xfer_len), .xfer_meta(xfer_meta), .xfer_swap(xfer_swap),
        .ring_stall(ring_stall), .wb_valid(wb_valid), .wb_slot(wb_slot),
        .wb_len(wb_len), .wb_flags(wb_flags), .wb_ack(wb_ack), .copy_done(copy_done)
    );

    always @(negedge clk) if (copy_done === 1'b1) cc_cnt++;

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    // starts and ends just after a falling edge
    task automatic send_frag(input logic more, input logic [15:0] len,
                             input logic [7:0] meta, input logic swap);
        xfer_valid = 1'b1;
        xfer_more  = more;
        xfer_len   = len;
        xfer_meta  = meta;
        xfer_swap  = swap;
        #1;
        while (xfer_ready !== 1'b1) @(negedge clk);
        @(negedge clk);
        xfer_valid = 1'b0;
        xfer_more  = 1'b0;
    endtask

    task automatic finish_xfer(input logic [15:0] len, input logic [7:0] meta,
                               input logic swap, input int dly);
        chk("R3 wb_valid raised", 32'(wb_valid), 32'd1);
        chk("R3 wb_slot", 32'(wb_slot), 32'(exp_slot % 8));
        chk("R3/R4 wb_len", 32'(wb_len), 32'(len));
        chk("R3/R4 wb_flags", 32'(wb_flags), 32'({meta, swap}));
        chk("R6 rd_idx before ack", 32'(rd_idx), 32'(exp_slot % 8));
        for (int k = 0; k < dly; k++) begin
            @(negedge clk);
            chk("R5 wb_valid held", 32'(wb_valid), 32'd1);
            chk("R5 wb_len held", 32'(wb_len), 32'(len));
            chk("R6 rd_idx waits for ack", 32'(rd_idx), 32'(exp_slot % 8));
        end
        wb_ack = 1'b1;
        @(negedge clk);
        wb_ack = 1'b0;
        exp_slot = (exp_slot + 1) % 8;
        chk("R7 copy_done with new index", 32'(copy_done), 32'd1);
        chk("R6 rd_idx advanced", 32'(rd_idx), 32'(exp_slot));
        chk("R5 wb_valid dropped", 32'(wb_valid), 32'd0);
        @(negedge clk);
        chk("R7 copy_done one cycle", 32'(copy_done), 32'd0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog all requirements actual=timeout expected=completion");
        summary();
        $finish;
    end

    initial begin
        logic [7:0] first_meta;
        logic       first_swap;
        logic [15:0] tot;
        logic       starting;
        int         c0;
        rst_n = 1'b0;
        host_wr_idx = '0;
        xfer_valid = 1'b0; xfer_more = 1'b0; xfer_len = '0; xfer_meta = '0; xfer_swap = 1'b0;
        wb_ack = 1'b0;
        first_meta = '0; first_swap = 1'b0; tot = '0; starting = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 rd_idx in reset", 32'(rd_idx), 32'd0);
        chk("R1 wb_valid in reset", 32'(wb_valid), 32'd0);
        chk("R1 copy_done in reset", 32'(copy_done), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 rd_idx after reset", 32'(rd_idx), 32'd0);
        chk("R1 wb_valid after reset", 32'(wb_valid), 32'd0);

        // table of single and gathered transfers (R3, R4, R5, R6, R7)
        host_wr_idx = 16'd7;
        for (int i = 0; i < NVEC; i++) begin
            logic [29:0] v;
            v = VEC[i];
            if (starting) begin
                first_meta = v[12:5];
                first_swap = v[4];
                tot = '0;
            end
            tot = tot + v[28:13];
            send_frag(v[29], v[28:13], v[12:5], v[4]);
            if (!v[29]) finish_xfer(tot, first_meta, first_swap, int'(v[3:0]));
            starting = !v[29];
        end
        chk("R4 five completions from table", 32'(cc_cnt), 32'd5);

        // R9: zero-length transfers, lone and gathered
        c0 = cc_cnt;
        send_frag(1'b0, 16'd0, 8'h99, 1'b1);
        repeat (3) begin
            chk("R9 no write-back for zero length", 32'(wb_valid), 32'd0);
            @(negedge clk);
        end
        send_frag(1'b1, 16'd0, 8'h9A, 1'b0);
        send_frag(1'b0, 16'd0, 8'h9B, 1'b0);
        repeat (2) @(negedge clk);
        chk("R9 no write-back for zero gather", 32'(wb_valid), 32'd0);
        chk("R9 rd_idx unchanged", 32'(rd_idx), 32'd5);
        chk("R9 no pulse", 32'(cc_cnt), 32'(c0));

        // R2: no posted buffer, upper index bits ignored
        host_wr_idx = 16'h0105;
        xfer_valid = 1'b1; xfer_more = 1'b0; xfer_len = 16'd7; xfer_meta = 8'hA5; xfer_swap = 1'b1;
        #1;
        chk("R2 ready low when empty", 32'(xfer_ready), 32'd0);
        chk("R2 stall high when empty", 32'(ring_stall), 32'd1);
        repeat (3) @(negedge clk);
        chk("R2 still stalled", 32'(ring_stall), 32'd1);
        chk("R2 no write-back while stalled", 32'(wb_valid), 32'd0);
        chk("R2 rd_idx while stalled", 32'(rd_idx), 32'd5);
        host_wr_idx = 16'h0106;
        #1;
        chk("R2 stall released", 32'(ring_stall), 32'd0);
        chk("R2 ready after posting", 32'(xfer_ready), 32'd1);
        send_frag(1'b0, 16'd7, 8'hA5, 1'b1);
        finish_xfer(16'd7, 8'hA5, 1'b1, 0);

        // R10 with R8: ring one behind, wrap through zero, then full
        host_wr_idx = 16'h0205;
        for (int i = 0; i < 7; i++) begin
            send_frag(1'b0, 16'(i + 1), 8'(8'h40 + i), i[0]);
            finish_xfer(16'(i + 1), 8'(8'h40 + i), i[0], i % 3);
            if (i == 1) chk("R8 wrap to slot 0", 32'(rd_idx), 32'd0);
        end
        chk("R10 slot after ring drained", 32'(rd_idx), 32'd5);
        xfer_valid = 1'b1; xfer_more = 1'b0; xfer_len = 16'd3; xfer_meta = 8'h01; xfer_swap = 1'b0;
        #1;
        chk("R10 stall after ring-size-minus-one", 32'(ring_stall), 32'd1);
        chk("R10 ready low when full", 32'(xfer_ready), 32'd0);
        repeat (2) @(negedge clk);
        chk("R10 no write-back when full", 32'(wb_valid), 32'd0);
        xfer_valid = 1'b0;
        @(negedge clk);
        chk("R2 stall drops without valid", 32'(ring_stall), 32'd0);

        summary();
        $finish;
    end
endmodule